// File: doc/BRIEF.md
# Replay Buffer Queue

This block is a single-clock first-in first-out queue for outgoing packet words that must survive until the far end confirms them. Words are pushed on a write port and popped on a read port in arrival order, with no address on either side. Reading a word does not free its slot. The slot stays reserved until an acknowledge strobe confirms everything read so far.

A retransmit strobe moves reading back to the oldest unconfirmed word. The same stretch of words can then be sent again as many times as needed. The full flag counts every unconfirmed word, whether it has been read or not, so a word that might still be replayed is never overwritten. The empty flag compares the live read position with the write position. Both flags are derived from registered pointers, so each holds steady for at least one whole clock cycle.

A typical user keeps a packet in the queue while it crosses a lossy link. It pulses acknowledge when the receiver reports a good packet, and pulses retransmit when the receiver reports a bad one.

Top module: `replay_fifo`

## Requirements
- R1: Words come out of rdData in the order they were accepted. The word for an accepted read (rdEn high while empty is low, without an effective retransmit) appears on rdData in the cycle after that read.
- R2: A read while empty is high is ignored. rdData keeps its value and empty stays high unless a write or retransmit intervenes.
- R3: A write while full is high is ignored. The rejected word never appears on rdData, and full stays high until an acknowledge.
- R4: full is high exactly when DEPTH words are unconfirmed, counting words already read. full can therefore be high together with empty.
- R5: A retransmit pulse, with acknowledge low, makes the next reads start again at the oldest unconfirmed word. Repeated pulses replay the same words each time.
- R6: An acknowledge pulse confirms every word read before that cycle. A word read in the same cycle stays unconfirmed. The freed slots clear full from the next cycle on, and a later retransmit starts at the first unconfirmed word.
- R7: When retransmit and acknowledge are high in the same cycle, acknowledge applies and retransmit is ignored.
- R8: In a cycle where retransmit takes effect, a read request is not accepted and rdData keeps its value.
- R9: With neither flag at its boundary, a read and a write in the same cycle are both accepted.
- R10: Synchronous reset (rst high at a clock edge) empties the queue. After it, empty is high, full is low and rdData is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request |
| wrData | input | WIDTH | Word to store |
| full | output | 1 | No free slot, since unconfirmed words fill the queue |
| rdEn | input | 1 | Read request |
| rdData | output | WIDTH | Registered word from the last accepted read |
| empty | output | 1 | No word left to read at the live read position |
| retransmit | input | 1 | Rewind reading to the oldest unconfirmed word |
| ack | input | 1 | Confirm all words read before this cycle |

## Verification
Acknowledge and retransmit can land in the same cycle, and either one can coincide with a read. The bench drives each of these collisions on purpose: acknowledge with a read, retransmit with a read, and both strobes together. It also lets them collide at random during a long mixed run. A queue-based reference model judges every cycle. In that model acknowledge drops the words read before the cycle, and retransmit resets the read index only when acknowledge is low. Any mismatch shows up as a wrong word on rdData or a wrong flag on the next cycle.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;
  // Strobes issued by the pointer control to the storage datapath.
  typedef struct packed {
    logic wrStrobe;  // store wrData at wrAddr this cycle
    logic rdStrobe;  // load rdData from rdAddr this cycle
  } fifoStrobe_t;
endpackage

// File: rtl/replay_fifo_ctrl.sv
module replay_fifo_ctrl
  import replay_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          retransmit,
  input  logic          ack,
  output logic          full,
  output logic          empty,
  output fifoStrobe_t   strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr
);
  // Each pointer carries one extra wrap bit above the slot index.
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic [PW-1:0] cmtPtr;
  logic          rewind;

  // Full is judged against the committed pointer, so that no unconfirmed word is overwritten.
  assign full   = (wrPtr[AW] != cmtPtr[AW]) && (wrPtr[AW-1:0] == cmtPtr[AW-1:0]);
  assign empty  = (rdPtr == wrPtr);
  // Acknowledge wins over retransmit.
  assign rewind = retransmit & ~ack;

  assign strobe.wrStrobe = wrEn & ~full;
  assign strobe.rdStrobe = rdEn & ~empty & ~rewind;
  assign wrAddr = wrPtr[AW-1:0];
  assign rdAddr = rdPtr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      cmtPtr <= '0;
    end else begin
      if (strobe.wrStrobe) wrPtr <= wrPtr + PW'(1);
      // Commit the position as it stood before any read in this cycle.
      if (ack) cmtPtr <= rdPtr;
      if (rewind)                rdPtr <= cmtPtr;
      else if (strobe.rdStrobe)  rdPtr <= rdPtr + PW'(1);
    end
  end
endmodule

// File: rtl/replay_fifo_data.sv
module replay_fifo_data
  import replay_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  fifoStrobe_t      strobe,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] store [DEPTH];

  // Storage has no reset. A slot is only read after it has been written.
  always_ff @(posedge clk) begin
    if (strobe.wrStrobe) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdData <= '0;
    else if (strobe.rdStrobe) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo
  import replay_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,  // power of two, at least 2
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             full,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  input  logic             retransmit,
  input  logic             ack
);
  fifoStrobe_t   strobe;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  replay_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn),
    .retransmit(retransmit), .ack(ack),
    .full(full), .empty(empty), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  replay_fifo_data #(.WIDTH(WIDTH), .DEPTH(DEPTH)) data_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/replay_fifo_chk.sv
module replay_fifo_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic             rdEn,
  input logic             retransmit,
  input logic             ack,
  input logic             full,
  input logic             empty,
  input logic [WIDTH-1:0] rdData
);
  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (empty && !full && rdData == '0));

  assert_full_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (full && !ack) |=> full);

  assert_empty_read_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (empty && !wrEn && !retransmit) |=> (empty && $stable(rdData)));

  assert_rewind_blocks_read_R8: assert property (@(posedge clk) disable iff (rst)
    (retransmit && !ack) |=> $stable(rdData));

  assert_ack_frees_R6: assert property (@(posedge clk) disable iff (rst)
    (full && empty && ack) |=> !full);
endmodule

bind replay_fifo replay_fifo_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn),
  .retransmit(retransmit), .ack(ack),
  .full(full), .empty(empty), .rdData(rdData)
);

// File: tb/replay_fifo_tb_top.sv
`timescale 1ns/1ps
module replay_fifo_tb_top;
  localparam int W = 8;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0, retransmit = 1'b0, ack = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic full, empty;

  always #2.5 clk = ~clk;

  replay_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .full(full),
    .rdEn(rdEn), .rdData(rdData), .empty(empty),
    .retransmit(retransmit), .ack(ack)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference model: unconfirmed words in order, plus a read index into them.
  logic [W-1:0] held[$];
  int rdIdx = 0;
  logic [W-1:0] expData = '0;

  task automatic checkVal(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic w, logic [W-1:0] d, logic r, logic rx, logic a, string tag);
    bit mEmpty, mFull, rdAcc, wrAcc;
    int newIdx;
    wrEn = w; wrData = d; rdEn = r; retransmit = rx; ack = a;
    mEmpty = (rdIdx == held.size());
    mFull  = (held.size() == D);
    rdAcc  = r && !mEmpty && !(rx && !a);
    wrAcc  = w && !mFull;
    newIdx = rdIdx;
    if (rdAcc) begin
      expData = held[rdIdx];
      newIdx++;
    end
    if (a) begin
      for (int k = 0; k < rdIdx; k++) void'(held.pop_front());
      newIdx -= rdIdx;
    end else if (rx) newIdx = 0;
    if (wrAcc) held.push_back(d);
    rdIdx = newIdx;
    @(negedge clk);
    checkVal(tag, "empty", int'(empty), int'(rdIdx == held.size()));
    checkVal(tag, "full", int'(full), int'(held.size() == D));
    checkVal(tag, "rdData", int'(rdData), int'(expData));
  endtask

  task automatic idle(string tag); step(0, '0, 0, 0, 0, tag); endtask
  task automatic wr(logic [W-1:0] d, string tag); step(1, d, 0, 0, 0, tag); endtask
  task automatic rd(string tag); step(0, '0, 1, 0, 0, tag); endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: flags and data after reset
    checkVal("R10", "empty", int'(empty), 1);
    checkVal("R10", "full", int'(full), 0);
    checkVal("R10", "rdData", int'(rdData), 0);
    rst = 1'b0;

    // R2: read on an empty queue
    rd("R2");
    // R1: ordered delivery
    for (int i = 0; i < 5; i++) wr(W'(8'h10 + i), "R1");
    // R9: simultaneous read and write at a mid fill level
    for (int i = 0; i < 4; i++) step(1, W'(8'h20 + i), 1, 0, 0, "R9");
    for (int i = 0; i < 5; i++) rd("R1");
    step(0, '0, 0, 0, 1, "R6");
    // R3: fill up, then offer one word too many
    for (int i = 0; i < D; i++) wr(W'(8'h40 + i), "R3");
    wr(8'hEE, "R3");
    wr(8'hEF, "R3");
    // R4: drain without confirming; full must stay high
    for (int i = 0; i < D; i++) rd("R4");
    rd("R2");
    // R5: replay repeatedly
    step(0, '0, 0, 1, 0, "R5");
    for (int i = 0; i < 3; i++) rd("R5");
    step(0, '0, 0, 1, 0, "R5");
    for (int i = 0; i < 3; i++) rd("R5");
    // R8: retransmit with a read request in the same cycle
    step(0, '0, 1, 1, 0, "R8");
    rd("R8");
    rd("R8");
    // R6: acknowledge with a read in the same cycle; only prior reads are confirmed
    step(0, '0, 1, 0, 1, "R6");
    wr(8'h77, "R6");
    step(0, '0, 0, 1, 0, "R6");
    rd("R6");
    rd("R6");
    // R7: both strobes together; acknowledge wins
    step(0, '0, 0, 1, 1, "R7");
    rd("R7");
    step(0, '0, 0, 1, 0, "R7");
    rd("R7");
    // Mixed traffic with random collisions
    for (int i = 0; i < 3000; i++) begin
      logic w, r, rx, a;
      w  = ($urandom_range(0, 9) < 6);
      r  = ($urandom_range(0, 9) < 5);
      rx = ($urandom_range(0, 15) == 0);
      a  = ($urandom_range(0, 11) == 0);
      step(w, W'($urandom), r, rx, a, "R1");
    end
    idle("R1");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule